// File: doc/BRIEF.md
# Protection-Entry Configuration Register Bank

This block is a 32-bit machine-mode control register. It holds the configuration bytes for four memory-protection entries, numbered 60 to 63. Software reaches it through a plain CSR-style port with an address, a write strobe, write data, a read strobe and combinational read data. Each byte is updated on its own. A byte stores what software writes only when that write is legal for it. Otherwise it keeps its old contents.

The block also drives the decoded fields of every entry straight to the access checker: the lock flag, the match mode and the execute/write/read permissions. The lock flag also tells the checker that the entry's rules cover machine-mode accesses. Two parameters set the behaviour:

- `NUM_ENTRIES` sets how many entries exist. Bytes whose entry index is `NUM_ENTRIES` or above are hardwired to zero.
- `GRAN` is the granularity exponent. At 2 or above, the four-byte match mode is illegal.

Top module: `pmpc_cfg_bank`

## Requirements
- R1: After reset every byte reads as 0x00, which means mode off and unlocked. A reset also releases any locked byte.
- R2: When `csr_re` is 1 and `csr_addr` equals 0x3AF, `csr_rdata` returns the stored register in the same cycle. Byte k (bits 8k+7:8k) belongs to entry 60+k. In every other case `csr_rdata` is 0.
- R3: A write needs `csr_we`=1 and `csr_addr`=0x3AF. For each legal byte, the write stores the byte in the next cycle, with bits 6:5 forced to 0. Inside a byte, bit 7 is lock, bits 4:3 are the mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), bit 2 is X, bit 1 is W and bit 0 is R.
- R4: While a byte's stored bit 7 is 1, writes leave that byte unchanged. Software cannot clear the lock.
- R5: A write byte with bit 0 (R)=0 and bit 1 (W)=1 is rejected, and the byte keeps its old value.
- R6: When `GRAN` is 2 or more, a write byte with bits 4:3 = 2 is rejected. When `GRAN` is below 2, such a byte is accepted.
- R7: A byte k with 60+k >= `NUM_ENTRIES` always reads 0 and ignores writes.
- R8: Each byte is judged on its own, so a rejected byte does not stop the other bytes of the same write from updating.
- R9: `lock_o[k]`, `mode_o[2k+1:2k]` and `perm_o[3k+2:3k]` (X,W,R) always equal bit 7, bits 4:3 and bits 2:0 of stored byte k.
- R10: A write strobe with a different address, or the right address with `csr_we`=0, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_re | input | 1 | Read strobe |
| csr_rdata | output | 32 | Read data, zero when not selected |
| lock_o | output | 4 | Lock / machine-mode-applies flag per entry |
| mode_o | output | 8 | Match mode per entry, 2 bits each |
| perm_o | output | 12 | X,W,R per entry, 3 bits each |

## Verification
The bench targets the following corner cases, listed with what a wrong design would do on each:

- **Reserved bits.** A byte is written with bits 6:5 set. A design that keeps those bits would read them back.
- **Reserved permission pair.** A write carries R=0, W=1 in every byte. A design that stores it would expose a write-only entry to the checker.
- **Four-byte mode.** The write is sent to two instances at once, one coarse and one fine. A design that ignores `GRAN` would either accept the mode on the coarse instance or reject it on the fine one.
- **Lock.** Entries are locked and then written with zeros. A design that lets the lock drop would come back unlocked.
- **Mixed write.** Legal and illegal bytes are combined in one write. A design that judges the whole word would drop the legal bytes.
- **Missing entries.** The second instance has only 62 entries. A design that stores bytes for missing entries would read them back as nonzero.

// File: rtl/pmpc_pkg.sv
package pmpc_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_TOR   = 2'd1,
        MODE_NA4   = 2'd2,
        MODE_NAPOT = 2'd3
    } match_mode_e;

    // One entry configuration byte; bit order is decoded by the checker.
    typedef struct packed {
        logic        lock;
        logic [1:0]  rsvd;
        match_mode_e mode;
        logic        x;
        logic        w;
        logic        r;
    } cfg_byte_t;

    localparam int CFG_BITS = $bits(cfg_byte_t);

endpackage

// File: rtl/pmpc_legal.sv
module pmpc_legal
    import pmpc_pkg::*;
#(
    parameter int GRAN = 2
) (
    input  cfg_byte_t  cur_i,
    input  logic [7:0] wbyte_i,
    output logic       accept_o,
    output cfg_byte_t  clean_o
);
    localparam bit COARSE = (GRAN >= 2);

    cfg_byte_t req;
    logic      bad_perm;
    logic      bad_mode;

    always_comb begin
        req      = cfg_byte_t'(wbyte_i);
        bad_perm = req.w && !req.r;
        bad_mode = COARSE && (req.mode == MODE_NA4);
        accept_o = !cur_i.lock && !bad_perm && !bad_mode;
        clean_o  = req;
        clean_o.rsvd = 2'b00;
    end

endmodule

// File: rtl/pmpc_slot.sv
module pmpc_slot
    import pmpc_pkg::*;
#(
    parameter bit IMPL = 1'b1,
    parameter int GRAN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wbyte,
    output cfg_byte_t  cfg_o
);
    generate
        if (IMPL) begin : g_impl
            typedef struct packed {
                cfg_byte_t cfg;
            } slot_state_t;

            slot_state_t st_d, st_q;
            logic        accept;
            cfg_byte_t   clean;

            pmpc_legal #(.GRAN(GRAN)) u_legal (
                .cur_i   (st_q.cfg),
                .wbyte_i (wbyte),
                .accept_o(accept),
                .clean_o (clean)
            );

            always_comb begin
                st_d = st_q;
                if (wr_en && accept) begin
                    st_d.cfg = clean;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign cfg_o = st_q.cfg;
        end else begin : g_absent
            assign cfg_o = '0;
        end
    endgenerate

endmodule

// File: rtl/pmpc_cfg_bank.sv
module pmpc_cfg_bank
    import pmpc_pkg::*;
#(
    parameter int          NUM_ENTRIES = 64,
    parameter int          GRAN        = 2,
    parameter int          BASE_ENTRY  = 60,
    parameter int          SLOTS       = 4,
    parameter int          AW          = 12,
    parameter logic [11:0] CSR_ADDR    = 12'h3AF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      csr_addr,
    input  logic               csr_we,
    input  logic [SLOTS*8-1:0] csr_wdata,
    input  logic               csr_re,
    output logic [SLOTS*8-1:0] csr_rdata,
    output logic [SLOTS-1:0]   lock_o,
    output logic [SLOTS*2-1:0] mode_o,
    output logic [SLOTS*3-1:0] perm_o
);
    localparam int DW = SLOTS * CFG_BITS;

    logic          hit;
    logic          wr;
    logic [DW-1:0] cfg_all;

    assign hit = (csr_addr == CSR_ADDR[AW-1:0]);
    assign wr  = csr_we && hit;

    generate
        for (genvar k = 0; k < SLOTS; k++) begin : g_slot
            cfg_byte_t cfg_k;

            pmpc_slot #(
                .IMPL((BASE_ENTRY + k) < NUM_ENTRIES),
                .GRAN(GRAN)
            ) u_slot (
                .clk  (clk),
                .rst_n(rst_n),
                .wr_en(wr),
                .wbyte(csr_wdata[8*k +: 8]),
                .cfg_o(cfg_k)
            );

            assign cfg_all[8*k +: 8] = cfg_k;
            assign lock_o[k]         = cfg_k.lock;
            assign mode_o[2*k +: 2]  = cfg_k.mode;
            assign perm_o[3*k +: 3]  = {cfg_k.x, cfg_k.w, cfg_k.r};
        end
    endgenerate

    always_comb begin
        csr_rdata = (csr_re && hit) ? cfg_all : '0;
    end

endmodule

// File: rtl/pmpc_cfg_chk.sv
module pmpc_cfg_chk #(
    parameter int          NUM_ENTRIES = 64,
    parameter int          GRAN        = 2,
    parameter int          BASE_ENTRY  = 60,
    parameter int          SLOTS       = 4,
    parameter int          AW          = 12,
    parameter logic [11:0] CSR_ADDR    = 12'h3AF
) (
    input logic               clk,
    input logic               rst_n,
    input logic [AW-1:0]      csr_addr,
    input logic               csr_re,
    input logic [SLOTS*8-1:0] csr_rdata,
    input logic [SLOTS*8-1:0] cfg_all,
    input logic [SLOTS-1:0]   lock_o
);
    // R2
    read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_re && csr_addr == CSR_ADDR[AW-1:0]) |-> csr_rdata == cfg_all);

    // R2
    read_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_re |-> csr_rdata == '0);

    generate
        for (genvar k = 0; k < SLOTS; k++) begin : g_k
            // R3
            rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_all[8*k+6 -: 2] == 2'b00);

            // R5
            no_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(cfg_all[8*k+1] && !cfg_all[8*k]));

            // R4
            locked_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_all[8*k+7] |=> $stable(cfg_all[8*k +: 8]));

            // R9
            lock_export_chk: assert property (@(posedge clk) disable iff (!rst_n)
                lock_o[k] == cfg_all[8*k+7]);

            if (GRAN >= 2) begin : g_coarse
                // R6
                no_na4_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    cfg_all[8*k+4 -: 2] != 2'd2);
            end

            if ((BASE_ENTRY + k) >= NUM_ENTRIES) begin : g_absent
                // R7
                absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    cfg_all[8*k +: 8] == 8'h00);
            end
        end
    endgenerate

endmodule

bind pmpc_cfg_bank pmpc_cfg_chk #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .GRAN       (GRAN),
    .BASE_ENTRY (BASE_ENTRY),
    .SLOTS      (SLOTS),
    .AW         (AW),
    .CSR_ADDR   (CSR_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .csr_addr (csr_addr),
    .csr_re   (csr_re),
    .csr_rdata(csr_rdata),
    .cfg_all  (cfg_all),
    .lock_o   (lock_o)
);

// File: tb/pmpc_cfg_bank_tb.sv
module pmpc_cfg_bank_tb;

    typedef struct {
        logic [31:0] exp_a;
        logic [31:0] exp_b;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic        csr_re = 1'b0;
    logic [31:0] rdata_a, rdata_b;
    logic [3:0]  lock_a, lock_b;
    logic [7:0]  mode_a, mode_b;
    logic [11:0] perm_a, perm_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    item_t sb[$];

    logic [7:0] ma [4];
    logic [7:0] mb [4];

    always #4 clk = ~clk;

    pmpc_cfg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_re(csr_re), .csr_rdata(rdata_a),
        .lock_o(lock_a), .mode_o(mode_a), .perm_o(perm_a)
    );

    pmpc_cfg_bank #(.NUM_ENTRIES(62), .GRAN(0)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_re(csr_re), .csr_rdata(rdata_b),
        .lock_o(lock_b), .mode_o(mode_b), .perm_o(perm_b)
    );

    // Model of one byte from R3..R7
    function automatic logic [7:0] nxt(input logic [7:0] old, input logic [7:0] wb,
                                       input int gran, input bit impl);
        if (!impl) return 8'h00;
        if (old[7]) return old;
        if (wb[1] && !wb[0]) return old;
        if (gran >= 2 && wb[4:3] == 2'd2) return old;
        return wb & 8'h9F;
    endfunction

    function automatic logic [31:0] pack(input logic [7:0] m [4]);
        return {m[3], m[2], m[1], m[0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 4; k++) begin
            ma[k] = 8'h00;
            mb[k] = 8'h00;
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic we, input logic [31:0] d);
        @(negedge clk);
        csr_addr = a; csr_we = we; csr_wdata = d; csr_re = 1'b0;
        if (we && a == 12'h3AF) begin
            for (int k = 0; k < 4; k++) begin
                ma[k] = nxt(ma[k], d[8*k +: 8], 2, 1'b1);
                mb[k] = nxt(mb[k], d[8*k +: 8], 0, (60 + k) < 62);
            end
        end
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, input logic re, input string tag);
        item_t it;
        @(negedge clk);
        csr_addr = a; csr_re = re; csr_we = 1'b0;
        it.tag = tag;
        it.exp_a = (re && a == 12'h3AF) ? pack(ma) : 32'h0;
        it.exp_b = (re && a == 12'h3AF) ? pack(mb) : 32'h0;
        sb.push_back(it);
        @(negedge clk);
        csr_re = 1'b0;
    endtask

    // Monitor: samples 3 ns after the driving edge, away from posedge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (sb.size() > 0) begin
                item_t it;
                logic [3:0]  el_a, el_b;
                logic [7:0]  em_a, em_b;
                logic [11:0] ep_a, ep_b;
                it = sb.pop_front();
                check({it.tag, " rdata a"}, rdata_a, it.exp_a);
                check({it.tag, " rdata b"}, rdata_b, it.exp_b);
                for (int k = 0; k < 4; k++) begin
                    el_a[k] = ma[k][7]; el_b[k] = mb[k][7];
                    em_a[2*k +: 2] = ma[k][4:3]; em_b[2*k +: 2] = mb[k][4:3];
                    ep_a[3*k +: 3] = ma[k][2:0]; ep_b[3*k +: 3] = mb[k][2:0];
                end
                check({it.tag, " R9 lock a"}, {28'h0, lock_a}, {28'h0, el_a});
                check({it.tag, " R9 lock b"}, {28'h0, lock_b}, {28'h0, el_b});
                check({it.tag, " R9 mode a"}, {24'h0, mode_a}, {24'h0, em_a});
                check({it.tag, " R9 mode b"}, {24'h0, mode_b}, {24'h0, em_b});
                check({it.tag, " R9 perm a"}, {20'h0, perm_a}, {20'h0, ep_a});
                check({it.tag, " R9 perm b"}, {20'h0, perm_b}, {20'h0, ep_b});
            end
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        do_read(12'h3AF, 1'b1, "R1 reset");
        // R3: reserved bits dropped; R7: bytes 2,3 absent in b
        do_write(12'h3AF, 1'b1, 32'h1F0D_0B67);
        do_read(12'h3AF, 1'b1, "R3 R7 first write");
        // R5: write-only pair everywhere
        do_write(12'h3AF, 1'b1, 32'h0202_0202);
        do_read(12'h3AF, 1'b1, "R5 write-only rejected");
        // R6 R8: four-byte mode in bytes 0,1,3, legal byte 2
        do_write(12'h3AF, 1'b1, 32'h1303_1113);
        do_read(12'h3AF, 1'b1, "R6 R8 mixed");
        // R4: lock bytes 0 and 3
        do_write(12'h3AF, 1'b1, 32'h8000_0081);
        do_read(12'h3AF, 1'b1, "R4 lock set");
        do_write(12'h3AF, 1'b1, 32'h0303_0303);
        do_read(12'h3AF, 1'b1, "R4 R8 lock held");
        // R10
        do_write(12'h3AE, 1'b1, 32'hFFFF_FFFF);
        do_write(12'h3AF, 1'b0, 32'h1B1B_1B1B);
        do_read(12'h3AF, 1'b1, "R10 no write");
        // R2
        do_read(12'h3AF, 1'b0, "R2 read strobe low");
        do_read(12'h3B0, 1'b1, "R2 other address");
        // R1: reset releases lock
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        do_read(12'h3AF, 1'b1, "R1 after second reset");
        do_write(12'h3AF, 1'b1, 32'h0F0F_0F0F);
        do_read(12'h3AF, 1'b1, "R1 R3 unlocked again");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule